// File: doc/BRIEF.md
# Floating-point status flag updater

This block holds the 32-bit status word of a floating-point unit and refreshes it each time the datapath finishes an arithmetic result. The datapath presents the result's sign and class, along with the exception flags that the operation raised, under a single-cycle valid strobe. On the next clock edge the block rewrites the four condition-code flags and replaces the exception byte with the new flags. It also ORs a summarised view of those flags into a sticky accrued field. All other bits of the word keep their values.

The same edge compares the new exception byte with an enable mask taken from the control register. When any enabled flag is set, a trap request is raised. A compare or test operation drives the same strobe, so its condition codes and flags land in the word even though no data register is written. A separate write port lets software load the whole word in one cycle. This port overrides a result that arrives in the same cycle.

Top module: `fp_status_flags`

## Requirements
- R1: A synchronous reset clears the whole status word to zero and holds the trap request low.
- R2: On a result strobe, bits 27:24 (negative 27, zero 26, infinity 25, NaN 24) are cleared and then set again from the result. The sign sets bit 27 for every class. Class code 1 (zero) sets bit 26. Code 2 (infinity) sets bit 25. Codes 3 (quiet NaN) and 4 (signalling NaN) set bit 24. Code 0 and codes 5 to 7 are ordinary numbers and set none of these bits.
- R3: A signalling-NaN result (class 4) also sets the signalling-NaN exception bit 14, even when the incoming exception flags leave that bit clear.
- R4: On a result strobe, the exception byte in bits 15:8 is replaced by the incoming flags, so flags from the previous result are not kept. The bit layout is: unordered-branch 15, signalling NaN 14, operand error 13, overflow 12, underflow 11, divide-by-zero 10, inexact result 9, inexact operand 8.
- R5: Accrued invalid (bit 7) is set when the new exception byte has bit 15, 14 or 13 set.
- R6: Accrued overflow (bit 6) is set by overflow (bit 12). Accrued divide-by-zero (bit 4) is set by divide-by-zero (bit 10).
- R7: Accrued underflow (bit 5) is set only when underflow (bit 11) and inexact result (bit 9) are both set in the new exception byte.
- R8: Accrued inexact (bit 3) is set when inexact operand (bit 8), inexact result (bit 9) or overflow (bit 12) is set.
- R9: Accrued bits 7:3 are sticky: a result only ORs into them and never clears them. Bits 31:28, 23:16 and 2:0 are left unchanged by results.
- R10: The trap request is high for exactly the cycle after a result strobe, and only when the new exception byte ANDed with the control enable byte is non-zero. The enable byte uses the same bit order as the exception byte.
- R11: A software write loads the whole word from the write data on the next edge. It takes priority over a result strobe in the same cycle, and that result then raises no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| res_valid | input | 1 | One-cycle strobe: a result is complete |
| res_sign | input | 1 | Sign of the result |
| res_class | input | 3 | Result class code |
| res_exc | input | 8 | Exception flags raised by the operation |
| ctrl_enable | input | 8 | Trap enable mask from the control register |
| sw_wr | input | 1 | Software write strobe |
| sw_data | input | 32 | Software write data |
| status | output | 32 | Current status word |
| trap_req | output | 1 | Trap request pulse |

## Verification
The hardest situations to reach from the ports are those where the accrued field must not change. The first is the underflow summary when only one of its two inputs is present. The second is a stale accrued bit that a later clean result must leave in place. The stimulus first uses software writes to plant chosen accrued and reserved bits. It then sends results with only underflow, only inexact, and then both, checking the whole word after each result. A result strobe is also sent in the same cycle as a software write, to show that the write wins and that no trap follows.

// File: rtl/fp_status_pkg.sv
package fp_status_pkg;
   localparam logic [2:0] CLS_NUM  = 3'd0;
   localparam logic [2:0] CLS_ZERO = 3'd1;
   localparam logic [2:0] CLS_INF  = 3'd2;
   localparam logic [2:0] CLS_QNAN = 3'd3;
   localparam logic [2:0] CLS_SNAN = 3'd4;

   // positions inside the exception byte
   localparam int EX_BSUN  = 7;
   localparam int EX_SNAN  = 6;
   localparam int EX_OPERR = 5;
   localparam int EX_OVFL  = 4;
   localparam int EX_UNFL  = 3;
   localparam int EX_DZ    = 2;
   localparam int EX_INEX2 = 1;
   localparam int EX_INEX1 = 0;

   // positions inside the accrued field
   localparam int AC_IOP  = 4;
   localparam int AC_OVFL = 3;
   localparam int AC_UNFL = 2;
   localparam int AC_DZ   = 1;
   localparam int AC_INEX = 0;

   // positions inside the condition-code nibble
   localparam int CC_NEG  = 3;
   localparam int CC_ZERO = 2;
   localparam int CC_INF  = 1;
   localparam int CC_NAN  = 0;

   localparam int EXC_W = 8;
   localparam int ACC_W = 5;
   localparam int CC_W  = 4;
endpackage

// File: rtl/fp_status_cc_gen.sv
module fp_status_cc_gen
   import fp_status_pkg::*;
(
   input  logic              sign,
   input  logic [2:0]        cls,
   output logic [CC_W-1:0]   cc,
   output logic              is_snan
);
   always_comb begin
      cc          = '0;
      cc[CC_NEG]  = sign;
      is_snan     = 1'b0;
      case (cls)
         CLS_ZERO: cc[CC_ZERO] = 1'b1;
         CLS_INF:  cc[CC_INF]  = 1'b1;
         CLS_QNAN: cc[CC_NAN]  = 1'b1;
         CLS_SNAN: begin
            cc[CC_NAN] = 1'b1;
            is_snan    = 1'b1;
         end
         default:  ;
      endcase
   end
endmodule

// File: rtl/fp_status_accrue.sv
module fp_status_accrue
   import fp_status_pkg::*;
(
   input  logic [EXC_W-1:0] exc,
   output logic [ACC_W-1:0] acc
);
   always_comb begin
      acc          = '0;
      acc[AC_IOP]  = exc[EX_BSUN] | exc[EX_SNAN] | exc[EX_OPERR];
      acc[AC_OVFL] = exc[EX_OVFL];
      acc[AC_UNFL] = exc[EX_UNFL] & exc[EX_INEX2];
      acc[AC_DZ]   = exc[EX_DZ];
      acc[AC_INEX] = exc[EX_INEX1] | exc[EX_INEX2] | exc[EX_OVFL];
   end
endmodule

// File: rtl/fp_status_flags.sv
module fp_status_flags
   import fp_status_pkg::*;
#(
   parameter int REG_W    = 32,
   parameter int CC_LSB   = 24,
   parameter int EXC_LSB  = 8,
   parameter int ACC_LSB  = 3,
   parameter bit TRAP_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              res_valid,
   input  logic              res_sign,
   input  logic [2:0]        res_class,
   input  logic [EXC_W-1:0]  res_exc,
   input  logic [EXC_W-1:0]  ctrl_enable,
   input  logic              sw_wr,
   input  logic [REG_W-1:0]  sw_data,
   output logic [REG_W-1:0]  status,
   output logic              trap_req
);
   localparam int CC_TOP  = CC_LSB + CC_W - 1;
   localparam int EXC_TOP = EXC_LSB + EXC_W - 1;
   localparam int ACC_TOP = ACC_LSB + ACC_W - 1;

   generate
      if (CC_TOP >= REG_W) begin : g_bad_cc
         $error("condition-code field exceeds register width");
      end
      if (ACC_TOP >= EXC_LSB) begin : g_bad_acc
         $error("accrued field overlaps exception byte");
      end
      if (EXC_TOP >= CC_LSB) begin : g_bad_exc
         $error("exception byte overlaps condition codes");
      end
   endgenerate

   logic [REG_W-1:0] status_q, status_d;
   logic [CC_W-1:0]  cc_new;
   logic             snan_hit;
   logic [EXC_W-1:0] exc_new;
   logic [ACC_W-1:0] acc_new;
   logic             take_res;

   fp_status_cc_gen u_cc (
      .sign    (res_sign),
      .cls     (res_class),
      .cc      (cc_new),
      .is_snan (snan_hit)
   );

   always_comb begin
      exc_new          = res_exc;
      exc_new[EX_SNAN] = res_exc[EX_SNAN] | snan_hit;
   end

   fp_status_accrue u_acc (
      .exc (exc_new),
      .acc (acc_new)
   );

   assign take_res = res_valid & ~sw_wr;

   always_comb begin
      status_d = status_q;
      if (sw_wr) begin
         status_d = sw_data;
      end else if (res_valid) begin
         status_d[CC_TOP:CC_LSB]   = cc_new;
         status_d[EXC_TOP:EXC_LSB] = exc_new;
         status_d[ACC_TOP:ACC_LSB] = status_q[ACC_TOP:ACC_LSB] | acc_new;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) status_q <= '0;
      else     status_q <= status_d;
   end

   assign status = status_q;

   generate
      if (TRAP_REG) begin : g_trap_pulse
         logic trap_q;
         always_ff @(posedge clk) begin
            if (rst) trap_q <= 1'b0;
            else     trap_q <= take_res & (|(exc_new & ctrl_enable));
         end
         assign trap_req = trap_q;
      end else begin : g_trap_level
         assign trap_req = |(status_q[EXC_TOP:EXC_LSB] & ctrl_enable);
      end
   endgenerate
endmodule

// File: rtl/fp_status_flags_chk.sv
module fp_status_flags_chk #(
   parameter int REG_W    = 32,
   parameter bit TRAP_REG = 1'b1
) (
   input logic             clk,
   input logic             rst,
   input logic             res_valid,
   input logic             res_sign,
   input logic [2:0]       res_class,
   input logic [7:0]       res_exc,
   input logic [7:0]       ctrl_enable,
   input logic             sw_wr,
   input logic [REG_W-1:0] sw_data,
   input logic [REG_W-1:0] status,
   input logic             trap_req
);
   AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> status == '0); // R1

   AST_NEG_FOLLOWS_SIGN: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !sw_wr) |=> status[27] == $past(res_sign)); // R2

   AST_ZERO_CLASS: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !sw_wr && res_class == 3'd1) |=> (status[26] && !status[25] && !status[24])); // R2

   AST_SNAN_FLAG: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !sw_wr && res_class == 3'd4) |=> (status[24] && status[14])); // R3

   AST_UNFL_GATED: assert property (@(posedge clk) disable iff (rst)
      (res_valid && !sw_wr && !status[5] && !(res_exc[3] && res_exc[1])) |=> !status[5]); // R7

   AST_ACCRUED_STICKY: assert property (@(posedge clk) disable iff (rst)
      !sw_wr |=> ((status[7:3] & $past(status[7:3])) == $past(status[7:3]))); // R9

   AST_SW_LOAD: assert property (@(posedge clk) disable iff (rst)
      sw_wr |=> status == $past(sw_data)); // R11

   generate
      if (TRAP_REG) begin : g_trap_chk
         AST_TRAP_RAISE: assert property (@(posedge clk) disable iff (rst)
            (res_valid && !sw_wr && |(res_exc & ctrl_enable)) |=> trap_req); // R10

         AST_TRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
            (!res_valid || sw_wr) |=> !trap_req); // R10
      end
   endgenerate
endmodule

bind fp_status_flags fp_status_flags_chk #(.REG_W(REG_W), .TRAP_REG(TRAP_REG)) u_chk (
   .clk(clk), .rst(rst), .res_valid(res_valid), .res_sign(res_sign),
   .res_class(res_class), .res_exc(res_exc), .ctrl_enable(ctrl_enable),
   .sw_wr(sw_wr), .sw_data(sw_data), .status(status), .trap_req(trap_req)
);

// File: tb/fp_status_flags_tb.sv
`timescale 1ns/1ps
module fp_status_flags_tb;
   logic        clk = 1'b0;
   logic        rst;
   logic        res_valid, res_sign, sw_wr;
   logic [2:0]  res_class;
   logic [7:0]  res_exc, ctrl_enable;
   logic [31:0] sw_data, status;
   logic        trap_req;
   int          checks = 0;
   int          failures = 0;
   logic [31:0] model_q = '0;

   always #2.5 clk = ~clk;

   fp_status_flags u_dut (
      .clk(clk), .rst(rst), .res_valid(res_valid), .res_sign(res_sign),
      .res_class(res_class), .res_exc(res_exc), .ctrl_enable(ctrl_enable),
      .sw_wr(sw_wr), .sw_data(sw_data), .status(status), .trap_req(trap_req)
   );

   // expected word after a result, from the requirements
   function automatic logic [31:0] expect_word(input logic [31:0] old, input logic s,
                                               input logic [2:0] c, input logic [7:0] e);
      logic [31:0] w;
      logic [7:0]  x;
      w = old;
      x = e;
      if (c == 3'd4) x[6] = 1'b1;                        // R3
      w[27] = s;                                         // R2
      w[26] = (c == 3'd1);
      w[25] = (c == 3'd2);
      w[24] = (c == 3'd3) || (c == 3'd4);
      w[15:8] = x;                                       // R4
      w[7] = w[7] | x[7] | x[6] | x[5];                  // R5
      w[6] = w[6] | x[4];                                // R6
      w[4] = w[4] | x[2];                                // R6
      w[5] = w[5] | (x[3] & x[1]);                       // R7
      w[3] = w[3] | x[0] | x[1] | x[4];                  // R8
      return w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic result(input string req, input logic s, input logic [2:0] c, input logic [7:0] e);
      logic [7:0] xe;
      xe = e | ((c == 3'd4) ? 8'h40 : 8'h00);
      res_valid = 1'b1; res_sign = s; res_class = c; res_exc = e;
      @(negedge clk);
      res_valid = 1'b0;
      model_q = expect_word(model_q, s, c, e);
      chk(req, status, model_q);
      chk("R10 trap", {31'd0, trap_req}, {31'd0, |(xe & ctrl_enable)});
   endtask

   task automatic swload(input logic [31:0] d);
      sw_wr = 1'b1; sw_data = d;
      @(negedge clk);
      sw_wr = 1'b0;
      model_q = d;
      chk("R11 load", status, d);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 status", status, 32'd0);
      chk("R1 trap", {31'd0, trap_req}, 32'd0);
      rst = 1'b0;
      model_q = '0;
   endtask

   task automatic t_classes();
      ctrl_enable = 8'h00;
      for (int c = 0; c < 8; c++) begin
         result("R2 class+", 1'b0, c[2:0], 8'h00);
         result("R2 class-", 1'b1, c[2:0], 8'h00);
      end
      result("R3 snan", 1'b1, 3'd4, 8'h00);
      result("R2 qnan after snan", 1'b0, 3'd3, 8'h00);
   endtask

   task automatic t_exc_replace();
      ctrl_enable = 8'h00;
      swload(32'h0);
      result("R4 set", 1'b0, 3'd0, 8'hA5);
      result("R4 replace", 1'b0, 3'd0, 8'h10);
   endtask

   task automatic t_fold();
      ctrl_enable = 8'h00;
      swload(32'h0); result("R5 bsun", 1'b0, 3'd0, 8'h80);
      swload(32'h0); result("R5 operr", 1'b0, 3'd0, 8'h20);
      swload(32'h0); result("R6 dz", 1'b0, 3'd0, 8'h04);
      swload(32'h0); result("R6 R8 ovfl", 1'b0, 3'd0, 8'h10);
      swload(32'h0); result("R8 inex1", 1'b0, 3'd0, 8'h01);
      swload(32'h0); result("R7 unfl only", 1'b0, 3'd1, 8'h08);
      chk("R7 no accrued unfl", {31'd0, status[5]}, 32'd0);
      result("R7 inex2 only", 1'b0, 3'd0, 8'h02);
      chk("R7 still clear", {31'd0, status[5]}, 32'd0);
      result("R7 both", 1'b0, 3'd0, 8'h0A);
      chk("R7 set", {31'd0, status[5]}, 32'd1);
   endtask

   task automatic t_sticky();
      ctrl_enable = 8'h00;
      swload(32'hF0A5_00F8 | 32'h0000_0007);
      result("R9 clean result", 1'b0, 3'd0, 8'h00);
      chk("R9 accrued held", {27'd0, status[7:3]}, 32'h1F);
      chk("R9 other bits", status & 32'hF0FF_0007, 32'hF0A5_0007);
   endtask

   task automatic t_trap();
      swload(32'h0);
      ctrl_enable = 8'h04;
      result("R10 enabled dz", 1'b0, 3'd0, 8'h04);
      @(negedge clk);
      chk("R10 one cycle", {31'd0, trap_req}, 32'd0);
      result("R10 disabled bit", 1'b0, 3'd0, 8'h10);
      ctrl_enable = 8'h40;
      result("R10 snan class trap", 1'b0, 3'd4, 8'h00);
      ctrl_enable = 8'h00;
   endtask

   task automatic t_priority();
      ctrl_enable = 8'hFF;
      swload(32'h0);
      sw_wr = 1'b1; sw_data = 32'h1234_0000;
      res_valid = 1'b1; res_sign = 1'b1; res_class = 3'd4; res_exc = 8'hFF;
      @(negedge clk);
      sw_wr = 1'b0; res_valid = 1'b0;
      model_q = 32'h1234_0000;
      chk("R11 write wins", status, 32'h1234_0000);
      chk("R11 no trap", {31'd0, trap_req}, 32'd0);
      ctrl_enable = 8'h00;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      rst = 1'b1; res_valid = 1'b0; res_sign = 1'b0; res_class = '0; res_exc = '0;
      ctrl_enable = '0; sw_wr = 1'b0; sw_data = '0;
      @(negedge clk);
      t_reset();
      t_classes();
      t_exc_replace();
      t_fold();
      t_sticky();
      t_trap();
      t_priority();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule